// File: doc/BRIEF.md
# Coefficient Store Handshake Controller

This block sequences the writing of calibration coefficients into an on-chip non-volatile array. The array's analog programming is modelled as a timed busy period that stands in for the charge-pump cycle. A store can begin in two ways. The calibration sequencer can raise a one-cycle automatic request that carries three coefficient words. Alternatively, software can do a manual store by toggling an active-low store bit in a control register that also holds a 7-bit data field.

When a store is accepted, the block emits a single-cycle capture pulse and copies the coefficients into its stored-word registers. It then holds a ready flag low for a fixed number of cycles. Software reads the stored words and the ready flag through a small register read port. The ready flag sits in the top bit of the status byte, above the third stored word.

Top module: `coef_store_ctrl`

## Requirements
- R1: After reset, ready is 1 and newdata is 0. The control register (address 0) reads 0x80, meaning the store bit is 1 and the data field is 0. Stored word A (address 1) reads 0x00, stored word B (address 2) reads 0x00, and the status byte (address 3) reads 0x80.
- R2: A manual store needs prog_en=1 and man_sel=1. It fires when a register write changes control bit 7 from 0 to 1. On the following clock edge, newdata goes high for exactly one cycle and control bits [6:0] are copied into stored word C, which is visible on status bits [6:0].
- R3: Ready (status bit 7 and the ready port) goes low in the same cycle as the newdata pulse. It stays low for exactly PROG_CYCLES cycles and then returns to 1.
- R4: An automatic store happens when auto_req is high at a clock edge with prog_en=1 and man_sel=0. It loads auto_word_a, auto_word_b and auto_word_c into stored words A, B and C. On that edge it also raises newdata for one cycle and starts the busy period.
- R5: While prog_en is 0, no request of either kind is accepted. No newdata pulse occurs, ready stays 1, and the stored words keep their values.
- R6: A request that arrives while ready is 0 is dropped and not queued. No newdata pulse follows when the busy period ends, and the stored words keep the values of the accepted store.
- R7: man_sel selects the only source that is allowed. With man_sel=1, auto_req has no effect. With man_sel=0, a 0-to-1 change of the store bit has no effect.
- R8: A write that sets the store bit to 0, or that writes 1 while the bit is already 1, starts no store.
- R9: Addresses 1 to 3 are read-only, and writes to them leave the stored words unchanged. Address 0 can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | Hardware programming enable |
| man_sel | input | 1 | 1 selects the manual store source, 0 selects the automatic source |
| auto_req | input | 1 | Automatic store request from the calibration sequencer |
| auto_word_a | input | 8 | Automatic coefficient word A |
| auto_word_b | input | 8 | Automatic coefficient word B |
| auto_word_c | input | 7 | Automatic coefficient word C |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| newdata | output | 1 | One-cycle capture pulse |
| ready | output | 1 | 1 when idle, 0 while programming |

## Verification
Manual stores are run with several data patterns: all ones, all zeros, alternating bits and a single bit. These show whether each bit of the data field reaches stored word C and whether the busy period has the exact length. An automatic store with distinct words checks that each word lands at its own address. Some stimuli must change nothing: a request with the enable low, a request from the wrong source, a request during busy, a falling or repeated store-bit write, and writes to the read-only addresses. Each of these is followed by read-backs and a pulse count, which separate ignored requests from queued or misrouted ones.

// File: rtl/coef_store_ctrl.sv
module coef_store_ctrl #(
  parameter int PROG_CYCLES = 40,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              man_sel,
  input  logic              auto_req,
  input  logic [DATA_W-1:0] auto_word_a,
  input  logic [DATA_W-1:0] auto_word_b,
  input  logic [DATA_W-2:0] auto_word_c,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              newdata,
  output logic              ready
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_WA   = 2'd1;
  localparam logic [1:0] A_WB   = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  logic              store_n, store_n_d;
  logic [DATA_W-2:0] ctrl_data;
  logic [DATA_W-1:0] word_a, word_b;
  logic [DATA_W-2:0] word_c;
  logic [CNT_W-1:0]  cnt;
  logic              fire_man, fire_auto;

  assign ready     = (cnt == '0);
  assign fire_man  = store_n & ~store_n_d & prog_en & man_sel & ready;
  assign fire_auto = auto_req & prog_en & ~man_sel & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_n   <= 1'b1;
      store_n_d <= 1'b1;
      ctrl_data <= '0;
    end else begin
      store_n_d <= store_n;
      if (wr_en && wr_addr == A_CTRL) begin
        store_n   <= wr_data[DATA_W-1];
        ctrl_data <= wr_data[DATA_W-2:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a  <= '0;
      word_b  <= '0;
      word_c  <= '0;
      cnt     <= '0;
      newdata <= 1'b0;
    end else begin
      newdata <= fire_man | fire_auto;
      if (fire_auto) begin
        word_a <= auto_word_a;
        word_b <= auto_word_b;
        word_c <= auto_word_c;
      end else if (fire_man) begin
        word_c <= ctrl_data;
      end
      if (fire_man || fire_auto) cnt <= CNT_W'(PROG_CYCLES);
      else if (!ready)           cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {store_n, ctrl_data};
      A_WA:    rd_data = word_a;
      A_WB:    rd_data = word_b;
      A_STAT:  rd_data = {ready, word_c};
      default: rd_data = '0;
    endcase
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    newdata |=> !newdata); // R2
  AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    newdata |-> !ready); // R3
  AST_START_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n)
    newdata |-> $past(prog_en)); // R5
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    newdata |-> $past(ready)); // R6
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !newdata |-> ($stable(word_c) && $stable(word_a) && $stable(word_b))); // R5
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(cnt) == CNT_W'(1)); // R3

endmodule

// File: tb/tb_coef_store_ctrl.sv
module tb_coef_store_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P = 40;

  logic clk = 0, rst_n = 0, prog_en = 0, man_sel = 0, auto_req = 0, wr_en = 0;
  logic [7:0] auto_word_a = 0, auto_word_b = 0, wr_data = 0, rd_data;
  logic [6:0] auto_word_c = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic newdata, ready;
  int tests = 0, fails = 0;

  localparam logic [6:0] MAN_VEC [4] = '{7'h7F, 7'h00, 7'h55, 7'h08};

  coef_store_ctrl #(.PROG_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .man_sel(man_sel),
    .auto_req(auto_req), .auto_word_a(auto_word_a), .auto_word_b(auto_word_b),
    .auto_word_c(auto_word_c), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .newdata(newdata), .ready(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_auto(logic [7:0] a, logic [7:0] b, logic [6:0] c);
    @(negedge clk);
    auto_req = 1; auto_word_a = a; auto_word_b = b; auto_word_c = c;
    @(negedge clk);
    auto_req = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 10 * P) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_pulses(int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      if (newdata) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    check("R1 ready", {7'd0, ready}, 8'd1);
    check("R1 newdata", {7'd0, newdata}, 8'd0);
    rd(2'd0, d); check("R1 ctrl", d, 8'h80);
    rd(2'd1, d); check("R1 word A", d, 8'h00);
    rd(2'd2, d); check("R1 word B", d, 8'h00);
    rd(2'd3, d); check("R1 status", d, 8'h80);
    rst_n = 1;
    @(negedge clk);

    prog_en = 1; man_sel = 1;
    foreach (MAN_VEC[i]) begin
      wr(2'd0, {1'b0, MAN_VEC[i]});
      count_pulses(3, n); check("R8 falling write no store", n[7:0], 8'd0);
      check("R8 ready after falling write", {7'd0, ready}, 8'd1);
      wr(2'd0, {1'b1, MAN_VEC[i]});
      check("R2 no pulse before edge", {7'd0, newdata}, 8'd0);
      @(negedge clk);
      check("R2 newdata pulse", {7'd0, newdata}, 8'd1);
      rd(2'd3, d); check("R2 captured word busy", d, {1'b0, MAN_VEC[i]});
      busy_len(n); check("R3 busy length", n[7:0], 8'(P));
      rd(2'd3, d); check("R3 status ready", d, {1'b1, MAN_VEC[i]});
    end

    wr(2'd0, 8'h80 | 8'h22);
    count_pulses(4, n); check("R8 repeated one no store", n[7:0], 8'd0);
    rd(2'd3, d); check("R8 status unchanged", d, 8'h88);
    rd(2'd0, d); check("R9 ctrl readback", d, 8'hA2);

    prog_en = 0;
    wr(2'd0, 8'h11);
    wr(2'd0, 8'h91);
    count_pulses(4, n); check("R5 manual rejected", n[7:0], 8'd0);
    check("R5 ready stays", {7'd0, ready}, 8'd1);
    rd(2'd3, d); check("R5 word C kept", d, 8'h88);
    man_sel = 0;
    pulse_auto(8'hDE, 8'hAD, 7'h3E);
    count_pulses(4, n); check("R5 auto rejected", n[7:0], 8'd0);
    rd(2'd1, d); check("R5 word A kept", d, 8'h00);

    prog_en = 1;
    pulse_auto(8'hA5, 8'h3C, 7'h2B);
    check("R4 newdata pulse", {7'd0, newdata}, 8'd1);
    check("R4 ready low", {7'd0, ready}, 8'd0);
    rd(2'd1, d); check("R4 word A", d, 8'hA5);
    rd(2'd2, d); check("R4 word B", d, 8'h3C);
    rd(2'd3, d); check("R4 word C busy", d, 8'h2B);
    busy_len(n); check("R4 busy length", n[7:0], 8'(P));

    man_sel = 1;
    pulse_auto(8'h01, 8'h02, 7'h03);
    count_pulses(4, n); check("R7 auto ignored in manual", n[7:0], 8'd0);
    rd(2'd1, d); check("R7 word A kept", d, 8'hA5);
    man_sel = 0;
    wr(2'd0, 8'h44);
    wr(2'd0, 8'hC4);
    count_pulses(4, n); check("R7 manual ignored in auto", n[7:0], 8'd0);
    rd(2'd3, d); check("R7 word C kept", d, 8'hAB);

    pulse_auto(8'h11, 8'h22, 7'h33);
    repeat (5) @(negedge clk);
    pulse_auto(8'h99, 8'h88, 7'h77);
    busy_len(n);
    count_pulses(P + 5, n); check("R6 no queued store", n[7:0], 8'd0);
    rd(2'd1, d); check("R6 word A", d, 8'h11);
    rd(2'd3, d); check("R6 status", d, 8'hB3);

    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h00);
    rd(2'd1, d); check("R9 word A read-only", d, 8'h11);
    rd(2'd3, d); check("R9 status read-only", d, 8'hB3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule